// File: doc/BRIEF.md
# Instruction Fetch Cache with Critical-Word-First Refill

This block is a read-only cache on a 32-bit processor's instruction fetch port. The CPU presents a fetch with two addresses. The effective address selects the set and the word. The translated physical address supplies the tag and the external address. A hit returns the instruction in the same cycle. A miss issues one burst request for the whole 32-byte line. The burst starts at the requested longword and wraps around the line. The CPU receives its word on the first data beat. The tag and valid bit are written only after the eighth beat.

The block is built as 2-way set-associative by default, with one least-recently-used bit per set. It can also be built direct-mapped. A fetch made while the cache is disabled, or to a non-cacheable area, goes out as a single-word read and leaves every array untouched. There are two resets. Power-on reset clears the valid and LRU bits. Manual reset clears only the valid bits.

Top module: `ifetch_cache`

## Requirements
- R1: A cached fetch whose line is present raises ready_o in the same cycle as req_i and returns the longword selected by ea_i[4:2]. It issues no memory request.
- R2: A cached miss raises mem_req_o with mem_single_o=0, mem_addr_o equal to pa_i with bits [4:0] cleared, and mem_start_o equal to the requested word index. These values hold until mem_ack_i.
- R3: On a miss, ready_o rises with the first accepted data beat, and that beat carries the requested word. No other fetch is answered until all eight beats have been taken.
- R4: Beats fill word positions start, start+1, … modulo 8. After the fill, every word of the line hits with its own data.
- R5: A hit needs a set valid bit and a stored tag equal to pa_i[28:10] in the set picked by ea_i[12:5]. A fetch to the same set with different tag bits misses.
- R6: In 2-way mode every cached access marks its way as most recent. A miss replaces the less recently used way of the set.
- R7: With en_i=0 or cacheable_i=0, a fetch issues one request with mem_single_o=1 and the word address of pa_i, and returns the beat's data. No tag, valid or LRU state changes.
- R8: A high man_rst_i at a clock edge invalidates every line and returns the control to idle. It leaves the LRU bits unchanged.
- R9: While rst_ni is low, every valid and LRU bit clears, mem_req_o and ready_o stay low, and the first cached fetch afterwards misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| man_rst_i | input | 1 | Manual reset, synchronous, active high |
| en_i | input | 1 | Cache enable |
| req_i | input | 1 | Fetch request, held until ready_o |
| cacheable_i | input | 1 | Fetch targets a cacheable area |
| ea_i | input | 32 | Effective address (set and word index) |
| pa_i | input | 32 | Translated physical address (tag, external address) |
| ready_o | output | 1 | Fetch answered this cycle |
| instr_o | output | 32 | Instruction word, valid with ready_o |
| mem_req_o | output | 1 | External read request, held until mem_ack_i |
| mem_single_o | output | 1 | 1: single-word read, 0: eight-beat line burst |
| mem_addr_o | output | 32 | Line base or word address |
| mem_start_o | output | 3 | First word index of the burst |
| mem_ack_i | input | 1 | Request taken by memory |
| mem_valid_i | input | 1 | Data beat valid |
| mem_rdata_i | input | 32 | Data beat |

## Verification
The properties assume the CPU keeps req_i, both addresses, en_i and cacheable_i steady from request to ready_o. They assume pa_i and ea_i agree in their page-offset bits, and that memory pulses mem_ack_i only while mem_req_o is high. They also assume memory returns exactly eight beats for a burst and one for a single read. The bench follows these rules: it drives pa_i equal to ea_i and holds every CPU input until it sees ready_o. Its memory model acknowledges only a pending request and emits the exact beat count in wrap order. It adds one idle gap in each burst so that beats are counted by mem_valid_i and not by cycles.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_FILL,
    ST_BYP
  } ifc_state_e;
endpackage

// File: rtl/ifc_tags.sv
module ifc_tags #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 19,
  parameter int WAYS  = 2,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  output logic [WAYS-1:0]  hit_vec_o,
  input  logic             wr_i,
  input  logic             wr_way_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  val_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel;

    assign sel = wr_i && (wr_way_i == 1'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      val_q <= '0;
      else if (clr_i)   val_q <= '0;
      else if (sel)     val_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) tag_q[wr_idx_i] <= wr_tag_i;
    end

    assign hit_vec_o[w] = val_q[rd_idx_i] && (tag_q[rd_idx_i] == cmp_tag_i);
  end
endmodule

// File: rtl/ifc_data.sv
module ifc_data #(
  parameter int IDX_W  = 8,
  parameter int WORDS  = 8,
  parameter int WAYS   = 2,
  localparam int SETS   = 1 << IDX_W,
  localparam int WORD_W = $clog2(WORDS),
  localparam int LINE_W = 32 * WORDS
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic              wr_way_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_way_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [31:0]       rd_data_o
);
  logic [31:0] way_rd [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    // no reset: contents are meaningless until the valid bit is set
    always_ff @(posedge clk_i) begin
      if (wr_i && (wr_way_i == 1'(w)))
        line_q[wr_idx_i][int'(wr_word_i)*32 +: 32] <= wr_data_i;
    end

    assign way_rd[w] = line_q[rd_idx_i][int'(rd_word_i)*32 +: 32];
  end

  if (WAYS == 2) begin : g_sel2
    assign rd_data_o = rd_way_i ? way_rd[WAYS-1] : way_rd[0];
  end else begin : g_sel1
    logic unused_way;
    assign unused_way = rd_way_i;
    assign rd_data_o  = way_rd[0];
  end
endmodule

// File: rtl/ifc_lru.sv
module ifc_lru #(
  parameter int IDX_W = 8,
  parameter int WAYS  = 2,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             victim_o,
  output logic [SETS-1:0]  lru_all_o
);
  if (WAYS == 2) begin : g_two
    logic [SETS-1:0] lru_q;
    // only power-on reset clears; manual reset has no path here
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lru_q <= '0;
      else if (upd_i) lru_q[upd_idx_i] <= ~upd_way_i;
    end
    assign victim_o  = lru_q[rd_idx_i];
    assign lru_all_o = lru_q;
  end else begin : g_one
    logic unused_upd;
    assign unused_upd = ^{clk_i, rst_ni, upd_i, upd_idx_i, upd_way_i, rd_idx_i};
    assign victim_o   = 1'b0;
    assign lru_all_o  = '0;
  end
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import ifc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int WORDS  = 8,
  parameter int IDX_LO = 5,
  parameter int IDX_W  = 8,
  parameter int TAG_LO = 10,
  parameter int TAG_W  = 19,
  parameter int WAYS   = 2,
  localparam int WORD_W = $clog2(WORDS),
  localparam int SETS   = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              en_i,
  input  logic              req_i,
  input  logic              cacheable_i,
  input  logic [AW-1:0]     ea_i,
  input  logic [AW-1:0]     pa_i,
  output logic              ready_o,
  output logic [31:0]       instr_o,
  output logic              mem_req_o,
  output logic              mem_single_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_start_o,
  input  logic              mem_ack_i,
  input  logic              mem_valid_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

  ifc_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              way_q;
  logic [WORD_W-1:0] wptr_q;
  logic [WORD_W-1:0] cnt_q;
  logic              single_q;
  logic [AW-1:0]     addr_q;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic [TAG_W-1:0]  ptag;
  logic              use_cache, accept, hit, cached_hit, cached_miss;
  logic [WAYS-1:0]   hit_vec;
  logic              hit_way, victim;
  logic [31:0]       hit_data;
  logic              beat, fill_done;
  logic [SETS-1:0]   lru_all;
  logic              unused_bits;

  assign idx       = ea_i[IDX_LO +: IDX_W];
  assign word      = ea_i[2 +: WORD_W];
  assign ptag      = pa_i[TAG_LO +: TAG_W];
  assign use_cache = en_i && cacheable_i;
  assign accept    = (state_q == ST_IDLE) && req_i && !man_rst_i;
  assign hit       = |hit_vec;
  assign hit_way   = (WAYS == 2) ? hit_vec[WAYS-1] : 1'b0;
  assign cached_hit  = accept && use_cache && hit;
  assign cached_miss = accept && use_cache && !hit;
  assign beat      = (state_q == ST_FILL) && mem_valid_i;
  assign fill_done = beat && (cnt_q == LAST_BEAT) && !man_rst_i;
  assign unused_bits = ^{ea_i, pa_i, lru_all};

  ifc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_tags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (man_rst_i),
    .rd_idx_i  (idx),
    .cmp_tag_i (ptag),
    .hit_vec_o (hit_vec),
    .wr_i      (fill_done),
    .wr_way_i  (way_q),
    .wr_idx_i  (idx_q),
    .wr_tag_i  (tag_q)
  );

  ifc_data #(.IDX_W(IDX_W), .WORDS(WORDS), .WAYS(WAYS)) u_data (
    .clk_i     (clk_i),
    .wr_i      (beat),
    .wr_way_i  (way_q),
    .wr_idx_i  (idx_q),
    .wr_word_i (wptr_q),
    .wr_data_i (mem_rdata_i),
    .rd_way_i  (hit_way),
    .rd_idx_i  (idx),
    .rd_word_i (word),
    .rd_data_o (hit_data)
  );

  ifc_lru #(.IDX_W(IDX_W), .WAYS(WAYS)) u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (cached_hit || cached_miss),
    .upd_idx_i (idx),
    .upd_way_i (cached_hit ? hit_way : victim),
    .rd_idx_i  (idx),
    .victim_o  (victim),
    .lru_all_o (lru_all)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      tag_q    <= '0;
      way_q    <= 1'b0;
      wptr_q   <= '0;
      cnt_q    <= '0;
      single_q <= 1'b0;
      addr_q   <= '0;
    end else if (man_rst_i) begin
      state_q  <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && !cached_hit) begin
            state_q  <= ST_REQ;
            single_q <= !use_cache;
            idx_q    <= idx;
            tag_q    <= ptag;
            way_q    <= victim;
            wptr_q   <= pa_i[2 +: WORD_W];
            addr_q   <= use_cache ? {pa_i[AW-1:IDX_LO], IDX_LO'(0)}
                                  : {pa_i[AW-1:2], 2'b00};
          end
        end
        ST_REQ: begin
          if (mem_ack_i) begin
            state_q <= single_q ? ST_BYP : ST_FILL;
            cnt_q   <= '0;
          end
        end
        ST_FILL: begin
          if (mem_valid_i) begin
            wptr_q <= wptr_q + 1'b1;  // wraps within the line
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == LAST_BEAT) state_q <= ST_IDLE;
          end
        end
        ST_BYP: begin
          if (mem_valid_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = cached_hit
                 || (beat && (cnt_q == '0))
                 || ((state_q == ST_BYP) && mem_valid_i);
  assign instr_o = cached_hit ? hit_data : mem_rdata_i;

  assign mem_req_o    = (state_q == ST_REQ);
  assign mem_single_o = single_q;
  assign mem_addr_o   = addr_q;
  assign mem_start_o  = wptr_q;
endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
  parameter int AW     = 32,
  parameter int WORD_W = 3,
  parameter int SETS   = 256
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              man_rst_i,
  input logic              en_i,
  input logic              req_i,
  input logic              cacheable_i,
  input logic              ready_o,
  input logic              mem_req_o,
  input logic              mem_single_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic [WORD_W-1:0] mem_start_o,
  input logic              mem_ack_i,
  input logic [SETS-1:0]   lru_all
);
  p_ready_has_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || man_rst_i)
    ready_o |-> req_i);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || man_rst_i)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_start_o)));

  p_no_ready_while_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || man_rst_i)
    mem_req_o |-> !ready_o);

  p_bypass_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || man_rst_i)
    $rose(mem_req_o) |-> (mem_single_o == !($past(en_i) && $past(cacheable_i))));

  p_lru_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> (lru_all == $past(lru_all)));
endmodule

bind ifetch_cache ifc_checker #(.AW(AW), .WORD_W(WORD_W), .SETS(SETS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .man_rst_i    (man_rst_i),
  .en_i         (en_i),
  .req_i        (req_i),
  .cacheable_i  (cacheable_i),
  .ready_o      (ready_o),
  .mem_req_o    (mem_req_o),
  .mem_single_o (mem_single_o),
  .mem_addr_o   (mem_addr_o),
  .mem_start_o  (mem_start_o),
  .mem_ack_i    (mem_ack_i),
  .lru_all      (lru_all)
);

// File: tb/ifetch_cache_bench.sv
`timescale 1ns/1ps
module ifetch_cache_bench;
  logic        clk = 1'b0;
  logic        rst_ni, man_rst_i, en_i, req_i, cacheable_i;
  logic [31:0] ea_i, pa_i, instr_o, mem_addr_o, mem_rdata_i;
  logic        ready_o, mem_req_o, mem_single_o, mem_ack_i, mem_valid_i;
  logic [2:0]  mem_start_o;

  int n_chk = 0, n_fail = 0, req_cnt = 0;
  logic        mem_busy = 1'b0;
  logic [31:0] last_addr;
  logic [2:0]  last_start;
  logic        last_single;

  always #4 clk = ~clk;  // 125 MHz

  ifetch_cache u_ifetch_cache (
    .clk_i(clk), .rst_ni(rst_ni), .man_rst_i(man_rst_i), .en_i(en_i), .req_i(req_i),
    .cacheable_i(cacheable_i), .ea_i(ea_i), .pa_i(pa_i), .ready_o(ready_o),
    .instr_o(instr_o), .mem_req_o(mem_req_o), .mem_single_o(mem_single_o),
    .mem_addr_o(mem_addr_o), .mem_start_o(mem_start_o), .mem_ack_i(mem_ack_i),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h3C3C_A5A5;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: acknowledges a pending request, then returns beats in wrap order
  initial begin
    mem_ack_i = 1'b0; mem_valid_i = 1'b0; mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (rst_ni && mem_req_o && !mem_busy) begin
        mem_busy = 1'b1; req_cnt++;
        last_addr = mem_addr_o; last_start = mem_start_o; last_single = mem_single_o;
        mem_ack_i = 1'b1;
        @(negedge clk);
        mem_ack_i = 1'b0;
        if (last_single) begin
          mem_valid_i = 1'b1; mem_rdata_i = mem_word(last_addr);
          @(negedge clk);
        end else begin
          for (int k = 0; k < 8; k++) begin
            if (k == 3) begin mem_valid_i = 1'b0; @(negedge clk); end
            mem_valid_i = 1'b1;
            mem_rdata_i = mem_word({last_addr[31:5], 3'(int'(last_start) + k), 2'b00});
            @(negedge clk);
          end
        end
        mem_valid_i = 1'b0; mem_busy = 1'b0;
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input logic cach, input logic en,
                       output logic [31:0] d, output int n);
    @(negedge clk);
    req_i = 1'b1; ea_i = a; pa_i = a; cacheable_i = cach; en_i = en; n = 0;
    #2;
    while (!ready_o && n < 200) begin @(negedge clk); #2; n++; end
    d = instr_o;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    #1;
    while (mem_busy) begin @(negedge clk); #1; end
  endtask

  localparam logic [31:0] A = 32'h0000_1068;   // set 0x83, word 2
  localparam logic [31:0] B = 32'h0000_0404;
  localparam logic [31:0] C = A + 32'h0000_2000; // same set, other tag
  localparam logic [31:0] D = A + 32'h1000_0000; // tag bit 28 differs
  localparam logic [31:0] E = 32'h0000_5ABC;

  task automatic t_reset();
    logic [31:0] d; int n, r0;
    chk(ready_o == 1'b0, "R9 ready after reset", 32'(ready_o), 0);
    chk(mem_req_o == 1'b0, "R9 no request after reset", 32'(mem_req_o), 0);
    r0 = req_cnt;
    fetch(A, 1, 1, d, n);
    chk(req_cnt == r0 + 1, "R9 first fetch misses", req_cnt, r0 + 1);
    chk(last_addr == 32'h0000_1060 && !last_single, "R2 line base, burst", last_addr, 32'h1060);
    chk(last_start == 3'd2, "R2 start word", 32'(last_start), 2);
    chk(n == 2, "R3 word on first beat", n, 2);
    chk(d == mem_word(A), "R3 critical word data", d, mem_word(A));
    wait_idle();
  endtask

  task automatic t_line_hits();
    logic [31:0] d, a; int n, r0;
    r0 = req_cnt;
    for (int w = 0; w < 8; w++) begin
      a = 32'h0000_1060 + 32'(w * 4);
      fetch(a, 1, 1, d, n);
      chk(n == 0 && d == mem_word(a), "R4 wrapped word hits", d, mem_word(a));
    end
    chk(req_cnt == r0, "R1 hits issue no request", req_cnt, r0);
  endtask

  task automatic t_hold_off();
    logic [31:0] d; int n, r0;
    fetch(B, 1, 1, d, n);
    r0 = req_cnt;
    fetch(A, 1, 1, d, n);  // would hit, but a fill is running
    chk(n >= 6, "R3 held until fill ends", n, 6);
    chk(d == mem_word(A) && req_cnt == r0, "R3 answered by hit after fill", d, mem_word(A));
    wait_idle();
    fetch(B, 1, 1, d, n);
    chk(n == 0 && d == mem_word(B), "R1 filled line hits", d, mem_word(B));
  endtask

  task automatic t_tags_lru();
    logic [31:0] d; int n, r0;
    r0 = req_cnt;
    fetch(C, 1, 1, d, n); wait_idle();
    chk(req_cnt == r0 + 1, "R5 other tag same set misses", req_cnt, r0 + 1);
    fetch(A, 1, 1, d, n);
    chk(n == 0 && d == mem_word(A), "R6 both ways held", d, mem_word(A));
    r0 = req_cnt;
    fetch(D, 1, 1, d, n); wait_idle();
    chk(req_cnt == r0 + 1, "R5 tag bit 28 mismatch misses", req_cnt, r0 + 1);
    r0 = req_cnt;
    fetch(A, 1, 1, d, n);
    chk(req_cnt == r0 && d == mem_word(A), "R6 recent way survives", d, mem_word(A));
    fetch(C, 1, 1, d, n); wait_idle();
    chk(req_cnt == r0 + 1, "R6 LRU way was evicted", req_cnt, r0 + 1);
  endtask

  task automatic t_bypass();
    logic [31:0] d; int n, r0;
    r0 = req_cnt;
    fetch(C, 1, 0, d, n); wait_idle();
    chk(req_cnt == r0 + 1 && last_single, "R7 disabled fetch single read", req_cnt, r0 + 1);
    chk(last_addr == C && d == mem_word(C), "R7 bypass address and data", last_addr, C);
    fetch(E, 0, 1, d, n); wait_idle();
    chk(req_cnt == r0 + 2 && last_single && d == mem_word(E), "R7 uncacheable single read", d, mem_word(E));
    r0 = req_cnt;
    fetch(C, 1, 1, d, n);
    chk(req_cnt == r0 && n == 0, "R7 cache unchanged by bypass", req_cnt, r0);
    fetch(E, 1, 1, d, n); wait_idle();
    chk(req_cnt == r0 + 1, "R7 bypass allocated nothing", req_cnt, r0 + 1);
  endtask

  task automatic t_manual_reset();
    logic [31:0] d; int n, r0;
    @(negedge clk); man_rst_i = 1'b1;
    @(negedge clk); man_rst_i = 1'b0;
    r0 = req_cnt;
    fetch(C, 1, 1, d, n); wait_idle();
    chk(req_cnt == r0 + 1, "R8 line invalid after manual reset", req_cnt, r0 + 1);
    fetch(C, 1, 1, d, n);
    chk(req_cnt == r0 + 1 && d == mem_word(C), "R8 refilled line hits", d, mem_word(C));
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; man_rst_i = 1'b0; en_i = 1'b1; req_i = 1'b0;
    cacheable_i = 1'b1; ea_i = '0; pa_i = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(ready_o == 1'b0 && mem_req_o == 1'b0, "R9 quiet in reset", 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    t_reset();
    t_line_hits();
    t_hold_off();
    t_tags_lru();
    t_bypass();
    t_manual_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule